// File: doc/BRIEF.md
# Multiplier-Free Constant Sum-of-Products Engine

This block forms a fixed weighted sum of several signed data words without a single multiplier. The weights are parameters. From them, each 4-input lookup table is filled at elaboration with every partial sum that its four address bits can select. Each table is addressed by four data bits that may come from different words and from neighbouring bit positions. The table outputs are shifted by the bit weight of their group and added in a registered binary adder tree. A new set of words can be accepted on every clock, and the result appears a fixed number of cycles later.

The bits are assigned to tables in position-major order. Flat bit index `f = pos * NUM_WORDS + word`, and table `k` reads flat bits `4k` to `4k+3`, with address bit `j` taken from flat bit `4k+j`. Any one table therefore sees at most two adjacent bit positions, which keeps its stored words narrow. The default configuration has six 10-bit words, 60 bits in all, read by fifteen tables. The inputs are two's complement. A table term driven by a sign bit (position `WORD_W-1`) is stored with a negative weight, so signed results come out exact. No control states are needed. The block is a pure valid-tagged pipeline with one table stage, `$clog2(N_LUT)` adder levels and one output register.

Top module: `lut_sop`

## Requirements
- R1: For each accepted input set, `out_sum` equals the exact signed sum of `c[w] * x[w]`. Word `w` occupies `in_words[w*10 +: 10]` as two's complement. The default weights are c0=3, c1=-7, c2=25, c3=-128, c4=127, c5=-64.
- R2: `out_valid` is high exactly 6 clock edges after the edge that sampled `in_valid` high. Back-to-back inputs give back-to-back results, in order.
- R3: An all-zero input set yields `out_sum` = 0.
- R4: A single set bit at position p < 9 of word w, with all other bits zero, yields `c[w] * 2^p`.
- R5: A word whose only set bit is the sign bit (value -512), with all other words zero, yields `-512 * c[w]`.
- R6: `out_sum` changes only in a cycle where `out_valid` is high. Input sets presented with `in_valid` low leave it unchanged.
- R7: Extreme inputs (every word at -512 or 511, chosen to maximise or minimise the sum) produce the exact result without overflow in the 22-bit output.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_sum` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set present this cycle |
| in_words | input | 60 | Six packed 10-bit signed words, word 0 in the low bits |
| out_valid | output | 1 | Result present this cycle |
| out_sum | output | 22 | Signed weighted sum |

## Verification
Accepting a new input set and delivering the result of one taken six cycles earlier happen in the same clock once the pipeline is full. Runs of back-to-back valid inputs are mixed with random gaps, so that loads, deliveries and idle holds interleave in every combination. Each delivered result is matched against a queue of expected sums and issue cycles. Every idle cycle checks that the held output did not move.

// File: rtl/lut_sop_pkg.sv
package lut_sop_pkg;

    // Bit position of a flat (position-major) bit index.
    function automatic int flat_pos(input int flat, input int nw);
        return flat / nw;
    endfunction

    // Word number of a flat bit index.
    function automatic int flat_word(input int flat, input int nw);
        return flat % nw;
    endfunction

    // Lowest bit position read by table k; the table output is shifted by it.
    function automatic int lut_base(input int k, input int nw);
        return (4 * k) / nw;
    endfunction

    // Number of distinct bit positions one 4-bit table can span.
    function automatic int pos_span(input int nw);
        return (4 + nw - 2) / nw + 1;
    endfunction

endpackage

// File: rtl/sop_lut.sv
module sop_lut #(
    parameter int LUT_IDX   = 0,
    parameter int NUM_WORDS = 6,
    parameter int WORD_W    = 10,
    parameter int COEF_W    = 8,
    parameter logic [NUM_WORDS*COEF_W-1:0] COEFS = '0,
    parameter int LUT_W     = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              addr,
    output logic signed [LUT_W-1:0] q
);
    import lut_sop_pkg::*;

    localparam int BASE = lut_base(LUT_IDX, NUM_WORDS);

    // Partial sum for one address; sign-bit terms carry a negative weight.
    function automatic int entry(input int a);
        int acc;
        acc = 0;
        for (int j = 0; j < 4; j++) begin
            if (((a >> j) & 1) == 1) begin
                int fl;
                int p;
                int w;
                int c;
                fl = 4 * LUT_IDX + j;
                p  = flat_pos(fl, NUM_WORDS);
                w  = flat_word(fl, NUM_WORDS);
                c  = int'($signed(COEFS[w*COEF_W +: COEF_W]));
                if (p == WORD_W - 1) acc = acc - (c <<< (p - BASE));
                else                 acc = acc + (c <<< (p - BASE));
            end
        end
        return acc;
    endfunction

    logic signed [LUT_W-1:0] rom [16];

    for (genvar a = 0; a < 16; a++) begin : g_rom
        assign rom[a] = LUT_W'(entry(a));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= rom[addr];
    end

    // R3: a table read with no selected bits contributes nothing.
    a_r3_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 4'd0) |=> (q == '0));

endmodule

// File: rtl/sop_add_tree.sv
module sop_add_tree #(
    parameter int N_IN = 15,
    parameter int W    = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_IN*W-1:0]     terms,
    output logic signed [W-1:0]   sum
);
    localparam int LEVELS = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int NPAD   = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : lv
        logic signed [W-1:0] node [NPAD];
        if (l == 0) begin : g_leaf
            always_comb begin
                for (int i = 0; i < NPAD; i++) begin
                    if (i < N_IN) node[i] = $signed(terms[i*W +: W]);
                    else          node[i] = '0;
                end
            end
        end else begin : g_add
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < NPAD; i++) node[i] <= '0;
                end else begin
                    for (int i = 0; i < (NPAD >> l); i++)
                        node[i] <= lv[l-1].node[2*i] + lv[l-1].node[2*i+1];
                    for (int i = (NPAD >> l); i < NPAD; i++)
                        node[i] <= '0;
                end
            end
        end
    end

    assign sum = lv[LEVELS].node[0];

endmodule

// File: rtl/lut_sop.sv
module lut_sop #(
    parameter int NUM_WORDS = 6,
    parameter int WORD_W    = 10,
    parameter int COEF_W    = 8,
    parameter logic [NUM_WORDS*COEF_W-1:0] COEFS = 48'hC0_7F_80_19_F9_03
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic [NUM_WORDS*WORD_W-1:0]              in_words,
    output logic                                     out_valid,
    output logic signed [COEF_W+WORD_W+$clog2(NUM_WORDS):0] out_sum
);
    import lut_sop_pkg::*;

    localparam int TOTAL_BITS = NUM_WORDS * WORD_W;
    localparam int N_LUT      = TOTAL_BITS / 4;
    localparam int SPAN       = pos_span(NUM_WORDS);
    localparam int LUT_W      = COEF_W + 2 + SPAN;
    localparam int SUM_W      = COEF_W + WORD_W + $clog2(NUM_WORDS) + 1;
    localparam int LEVELS     = (N_LUT > 1) ? $clog2(N_LUT) : 1;
    localparam int LAT        = LEVELS + 2;
    localparam longint MAX_ABS = longint'(NUM_WORDS) * (longint'(1) << (COEF_W - 1))
                                 * (longint'(1) << (WORD_W - 1));

    logic [N_LUT*SUM_W-1:0] terms;
    logic signed [SUM_W-1:0] tree_sum;
    logic [LEVELS:0]         vpipe;

    for (genvar k = 0; k < N_LUT; k++) begin : g_lut
        localparam int BASE = lut_base(k, NUM_WORDS);
        logic [3:0]              addr;
        logic signed [LUT_W-1:0] q;
        logic signed [SUM_W-1:0] ext;

        for (genvar j = 0; j < 4; j++) begin : g_bit
            localparam int FL = 4 * k + j;
            assign addr[j] = in_words[flat_word(FL, NUM_WORDS)*WORD_W
                                      + flat_pos(FL, NUM_WORDS)];
        end

        sop_lut #(
            .LUT_IDX  (k),
            .NUM_WORDS(NUM_WORDS),
            .WORD_W   (WORD_W),
            .COEF_W   (COEF_W),
            .COEFS    (COEFS),
            .LUT_W    (LUT_W)
        ) u_lut (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (addr),
            .q    (q)
        );

        assign ext = {{(SUM_W-LUT_W){q[LUT_W-1]}}, q};
        assign terms[k*SUM_W +: SUM_W] = ext <<< BASE;
    end

    sop_add_tree #(
        .N_IN(N_LUT),
        .W   (SUM_W)
    ) u_tree (
        .clk  (clk),
        .rst_n(rst_n),
        .terms(terms),
        .sum  (tree_sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe     <= '0;
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            vpipe     <= {vpipe[LEVELS-1:0], in_valid};
            out_valid <= vpipe[LEVELS];
            if (vpipe[LEVELS]) out_sum <= tree_sum;
        end
    end

    // Cycles since reset, saturating, so the latency check never looks before reset.
    logic [7:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
    end

    // R2: fixed latency from accepted input to delivered result.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst > 8'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

    // R6: the held result moves only when a result is delivered.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_sum) |-> out_valid);

    // R7: the result never leaves the range of the largest possible sum.
    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((longint'(out_sum) <= MAX_ABS) && (longint'(out_sum) >= -MAX_ABS)));

endmodule

// File: tb/tb_lut_sop.sv
module tb_lut_sop;
    localparam int NW = 6;
    localparam int WW = 10;
    localparam int SW = 22;

    logic              clk;
    logic              rst_n;
    logic              in_valid;
    logic [NW*WW-1:0]  in_words;
    logic              out_valid;
    logic signed [SW-1:0] out_sum;

    int checks;
    int fails;
    int cyc;
    int coef [NW] = '{3, -7, 25, -128, 127, -64};

    int    exp_q  [$];
    int    stamp_q[$];
    string tag_q  [$];
    logic signed [SW-1:0] last_sum;

    lut_sop dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_words (in_words),
        .out_valid(out_valid),
        .out_sum  (out_sum)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic int ref_sum(input logic [NW*WW-1:0] w);
        int acc;
        acc = 0;
        for (int i = 0; i < NW; i++)
            acc += coef[i] * int'($signed(w[i*WW +: WW]));
        return acc;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Compare the outputs seen at this falling edge with the queued expectations.
    task automatic monitor();
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                check("R2", 1, 0);
            end else begin
                int e;
                int s;
                string t;
                e = exp_q.pop_front();
                s = stamp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(out_sum), e);
                check("R2", cyc - s, 6);
            end
        end else begin
            check("R6", int'(out_sum), int'(last_sum));
        end
        last_sum = out_sum;
    endtask

    task automatic cycle(input logic v, input logic [NW*WW-1:0] w, input string req);
        @(negedge clk);
        cyc++;
        monitor();
        in_valid = v;
        in_words = w;
        if (v) begin
            exp_q.push_back(ref_sum(w));
            stamp_q.push_back(cyc);
            tag_q.push_back(req);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [NW*WW-1:0] w;
        checks   = 0;
        fails    = 0;
        cyc      = 0;
        last_sum = '0;
        void'($urandom(32'd20417));
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_words = '0;
        repeat (3) @(negedge clk);
        check("R8", int'(out_valid), 0);
        check("R8", int'(out_sum), 0);
        rst_n = 1'b1;

        // R3: all-zero words
        cycle(1'b1, '0, "R3");
        // R6: garbage with in_valid low must be ignored
        cycle(1'b0, {NW*WW{1'b1}}, "R6");
        cycle(1'b0, 60'h5A5_A5A5_A5A5_A5A5, "R6");
        repeat (8) cycle(1'b0, '0, "R6");

        // R4 / R5: every bit alone, back to back
        for (int wd = 0; wd < NW; wd++) begin
            for (int p = 0; p < WW; p++) begin
                w = '0;
                w[wd*WW + p] = 1'b1;
                cycle(1'b1, w, (p == WW - 1) ? "R5" : "R4");
            end
        end
        repeat (8) cycle(1'b0, '0, "R6");

        // R7: extremes
        cycle(1'b1, {NW{10'h200}}, "R7");
        cycle(1'b1, {NW{10'h1FF}}, "R7");
        w = '0;
        for (int i = 0; i < NW; i++) w[i*WW +: WW] = (coef[i] < 0) ? 10'h200 : 10'h1FF;
        cycle(1'b1, w, "R7");
        for (int i = 0; i < NW; i++) w[i*WW +: WW] = (coef[i] < 0) ? 10'h1FF : 10'h200;
        cycle(1'b1, w, "R7");
        repeat (8) cycle(1'b0, '0, "R6");

        // R1: random sets with random gaps
        for (int n = 0; n < 600; n++) begin
            for (int i = 0; i < NW; i++) w[i*WW +: WW] = 10'($urandom);
            cycle(($urandom % 10) < 7, w, "R1");
        end
        repeat (10) cycle(1'b0, '0, "R6");
        check("R2", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule